// File: doc/BRIEF.md
# I2C Master/Slave Mode Controller

This block holds the operating mode of a combined I2C master/slave port. Two state bits are visible to software. The master-select bit (`mss_o`) and the activity bit (`act_o`) together name one of four states: idle (0/0), slave-active (0/1), master-pending (1/0) and master-active (1/1). Software asks for master operation, a repeated start or a stop through a register-write port. The bus-condition detectors report stop, bus-busy, own-address match, acknowledged reserved address, arbitration loss and bus error.

The block sends single-cycle start, repeated-start and stop requests to the bit-level engine. It also keeps an interrupt flag and two sticky error flags.

A master request made while the bus is busy waits in the pending state. The start request is issued once the bus is free. If the port is addressed as a slave while the request is waiting, the request is dropped and arbitration loss is flagged. The interrupt flag is a simple model. It rises on byte completion and on events, and it falls when the register write rules say it should.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset, every output is 0, which is the idle state.
- R2: A write with master-select 1 in idle sets `mss_o` on that edge. With the bus free, the next edge sets `act_o` and pulses `gen_start_o` high for one cycle. A write with master-select 0 while pending returns the block to idle.
- R3: While pending and `bus_busy_i` is 1, no start is requested and the state holds. The start is requested on the first edge at which `bus_busy_i` is 0.
- R4: An own-address match while pending clears `mss_o` and sets `act_o`, `al_o` and `int_o` on the same edge.
- R5: A write with master-select 0 while master-active and `int_o`=1 pulses `gen_stop_o` and clears `int_o`. `mss_o` stays 1 until `ev_stop_i`, and then the next edge clears both `mss_o` and `act_o`. The same write while `int_o`=0 has no effect.
- R6: When enabled, `bus_err_i` clears `mss_o` and `act_o` and sets `ber_o` and `int_o`.
- R7: When enabled, `arb_lost_i` clears `mss_o` and `act_o` and sets `al_o` and `int_o`.
- R8: A write with repeated-start 1 and master-select 1 while master-active and `int_o`=1 pulses `gen_rstart_o` and clears `int_o`. The same write is ignored when `int_o`=0, when the block is slave-active, or when repeated-start is 0.
- R9: A write with repeated-start 1 and master-select 0 in the same cycle acts as a stop request only. No repeated start is requested.
- R10: While `en_i` is 0, `mss_o` and `act_o` are held at 0. Mode writes and bus events are ignored.
- R11: `al_o` and `ber_o` stay set until a write with `wr_flag_clr_i`=1.
- R12: In idle, an own-address match or an acknowledged reserved address sets `act_o` and `int_o` and leaves `mss_o` at 0. `ev_stop_i` then clears `act_o`.
- R13: `byte_done_i` while `act_o`=1 sets `int_o`. A write with `wr_int_i`=0 clears `int_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| wr_i | input | 1 | Control register write strobe |
| wr_mss_i | input | 1 | Master-select value written |
| wr_scc_i | input | 1 | Repeated-start request value written |
| wr_int_i | input | 1 | Interrupt flag value written (0 clears) |
| wr_flag_clr_i | input | 1 | Clears the sticky error flags when written 1 |
| bus_busy_i | input | 1 | Bus busy from the condition detector |
| ev_stop_i | input | 1 | Stop condition detected |
| addr_match_i | input | 1 | Own slave address matched |
| rsv_ack_i | input | 1 | Reserved address detected and acknowledged |
| arb_lost_i | input | 1 | Arbitration lost |
| bus_err_i | input | 1 | Bus error detected |
| byte_done_i | input | 1 | Byte transfer with acknowledge finished |
| mss_o | output | 1 | Master-select read value |
| act_o | output | 1 | Activity flag |
| int_o | output | 1 | Interrupt flag |
| al_o | output | 1 | Sticky arbitration-lost flag |
| ber_o | output | 1 | Sticky bus-error flag |
| gen_start_o | output | 1 | Start generation request, one cycle |
| gen_rstart_o | output | 1 | Repeated-start generation request, one cycle |
| gen_stop_o | output | 1 | Stop generation request, one cycle |

## Verification
The assertions assume that the bit engine and software follow these rules:
- Detector events arrive as single-cycle pulses.
- `byte_done_i` never arrives in the same cycle as a write that clears the interrupt.
- A mode write and a bus event never arrive together, because event priority would otherwise discard the write.

The stimulus applies one event or one write per cycle and holds `bus_busy_i` as a level. It raises `byte_done_i` only when the block is active and the interrupt is clear, as a byte engine stalled on a pending interrupt would.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;

  // encoding is {mss, act}
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_PEND   = 2'b10,
    MODE_MASTER = 2'b11
  } mode_e;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
  } gen_req_t;

endpackage

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm
  import i2c_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     wr_i,
  input  logic     wr_mss_i,
  input  logic     wr_scc_i,
  input  logic     int_i,
  input  logic     bus_busy_i,
  input  logic     ev_stop_i,
  input  logic     addr_match_i,
  input  logic     rsv_ack_i,
  input  logic     arb_lost_i,
  input  logic     bus_err_i,
  output logic     mss_o,
  output logic     act_o,
  output gen_req_t req_o,
  output logic     set_al_o,
  output logic     set_ber_o,
  output logic     set_int_o,
  output logic     clr_int_o
);

  logic     mss_q, mss_d;
  logic     act_q, act_d;
  logic     stop_q, stop_d;
  gen_req_t req_q, req_d;
  mode_e    mode;

  assign mode = mode_e'({mss_q, act_q});

  always_comb begin
    mss_d     = mss_q;
    act_d     = act_q;
    stop_d    = stop_q;
    req_d     = '0;
    set_al_o  = 1'b0;
    set_ber_o = 1'b0;
    set_int_o = 1'b0;
    clr_int_o = 1'b0;
    if (!en_i) begin
      mss_d  = 1'b0;
      act_d  = 1'b0;
      stop_d = 1'b0;
    end else if (bus_err_i) begin
      mss_d     = 1'b0;
      act_d     = 1'b0;
      stop_d    = 1'b0;
      set_ber_o = 1'b1;
      set_int_o = 1'b1;
    end else if (arb_lost_i) begin
      mss_d     = 1'b0;
      act_d     = 1'b0;
      stop_d    = 1'b0;
      set_al_o  = 1'b1;
      set_int_o = 1'b1;
    end else if (ev_stop_i && mode != MODE_PEND) begin
      // a pending request survives a stop and keeps waiting
      act_d  = 1'b0;
      stop_d = 1'b0;
      if (mode == MODE_MASTER) mss_d = 1'b0;
    end else begin
      unique case (mode)
        MODE_IDLE: begin
          if (addr_match_i || rsv_ack_i) begin
            act_d     = 1'b1;
            set_int_o = 1'b1;
          end else if (wr_i && wr_mss_i) begin
            mss_d = 1'b1;
          end
        end
        MODE_SLAVE: ;
        MODE_PEND: begin
          if (addr_match_i) begin
            mss_d     = 1'b0;
            act_d     = 1'b1;
            set_al_o  = 1'b1;
            set_int_o = 1'b1;
          end else if (wr_i && !wr_mss_i) begin
            mss_d = 1'b0;
          end else if (!bus_busy_i) begin
            act_d       = 1'b1;
            req_d.start = 1'b1;
          end
        end
        MODE_MASTER: begin
          if (wr_i && int_i && !stop_q) begin
            if (!wr_mss_i) begin
              // stop wins over a repeated start written together
              stop_d     = 1'b1;
              req_d.stop = 1'b1;
              clr_int_o  = 1'b1;
            end else if (wr_scc_i) begin
              req_d.rstart = 1'b1;
              clr_int_o    = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q  <= 1'b0;
      act_q  <= 1'b0;
      stop_q <= 1'b0;
      req_q  <= '0;
    end else begin
      mss_q  <= mss_d;
      act_q  <= act_d;
      stop_q <= stop_d;
      req_q  <= req_d;
    end
  end

  assign mss_o = mss_q;
  assign act_o = act_q;
  assign req_o = req_q;

  p_start_from_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.start |-> (mss_q && act_q && $past(mss_q && !act_q)));

  p_no_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.start |-> !$past(bus_busy_i));

  p_match_cancels_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mss_q && !act_q && addr_match_i && !bus_err_i && !arb_lost_i)
      |=> (!mss_q && act_q));

  p_stop_keeps_mss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.stop |-> (mss_q && act_q));

  p_berr_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bus_err_i) |=> (!mss_q && !act_q));

  p_al_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && arb_lost_i) |=> (!mss_q && !act_q));

  p_req_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_q.start, req_q.rstart, req_q.stop}));

  p_disable_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mss_q && !act_q && !req_q.start));

endmodule

// File: rtl/i2c_mode_flags.sv
module i2c_mode_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic act_i,
  input  logic wr_i,
  input  logic wr_int_i,
  input  logic wr_flag_clr_i,
  input  logic byte_done_i,
  input  logic set_al_i,
  input  logic set_ber_i,
  input  logic set_int_i,
  input  logic clr_int_i,
  output logic int_o,
  output logic al_o,
  output logic ber_o
);

  logic int_q, al_q, ber_q;
  logic int_set, int_clr, err_clr;

  assign int_set = set_int_i || (en_i && act_i && byte_done_i);
  assign int_clr = clr_int_i || (wr_i && !wr_int_i);
  assign err_clr = wr_i && wr_flag_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      al_q  <= 1'b0;
      ber_q <= 1'b0;
    end else begin
      if (int_set)      int_q <= 1'b1;
      else if (int_clr) int_q <= 1'b0;
      if (set_al_i)     al_q  <= 1'b1;
      else if (err_clr) al_q  <= 1'b0;
      if (set_ber_i)    ber_q <= 1'b1;
      else if (err_clr) ber_q <= 1'b0;
    end
  end

  assign int_o = int_q;
  assign al_o  = al_q;
  assign ber_o = ber_q;

  p_ber_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ber_i |=> (ber_q && int_q));

  p_al_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_al_i |=> (al_q && int_q));

  p_al_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_q && !err_clr) |=> al_q);

  p_ber_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ber_q && !err_clr) |=> ber_q);

  p_int_on_byte_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && act_i && byte_done_i) |=> int_q);

endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic wr_mss_i,
  input  logic wr_scc_i,
  input  logic wr_int_i,
  input  logic wr_flag_clr_i,
  input  logic bus_busy_i,
  input  logic ev_stop_i,
  input  logic addr_match_i,
  input  logic rsv_ack_i,
  input  logic arb_lost_i,
  input  logic bus_err_i,
  input  logic byte_done_i,
  output logic mss_o,
  output logic act_o,
  output logic int_o,
  output logic al_o,
  output logic ber_o,
  output logic gen_start_o,
  output logic gen_rstart_o,
  output logic gen_stop_o
);

  gen_req_t req;
  logic     set_al, set_ber, set_int, clr_int;
  logic     int_flag;

  i2c_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .wr_i         (wr_i),
    .wr_mss_i     (wr_mss_i),
    .wr_scc_i     (wr_scc_i),
    .int_i        (int_flag),
    .bus_busy_i   (bus_busy_i),
    .ev_stop_i    (ev_stop_i),
    .addr_match_i (addr_match_i),
    .rsv_ack_i    (rsv_ack_i),
    .arb_lost_i   (arb_lost_i),
    .bus_err_i    (bus_err_i),
    .mss_o        (mss_o),
    .act_o        (act_o),
    .req_o        (req),
    .set_al_o     (set_al),
    .set_ber_o    (set_ber),
    .set_int_o    (set_int),
    .clr_int_o    (clr_int)
  );

  i2c_mode_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .act_i         (act_o),
    .wr_i          (wr_i),
    .wr_int_i      (wr_int_i),
    .wr_flag_clr_i (wr_flag_clr_i),
    .byte_done_i   (byte_done_i),
    .set_al_i      (set_al),
    .set_ber_i     (set_ber),
    .set_int_i     (set_int),
    .clr_int_i     (clr_int),
    .int_o         (int_flag),
    .al_o          (al_o),
    .ber_o         (ber_o)
  );

  assign int_o        = int_flag;
  assign gen_start_o  = req.start;
  assign gen_rstart_o = req.rstart;
  assign gen_stop_o   = req.stop;

  p_int_cleared_by_rs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rstart_o |-> (mss_o && act_o && $past(int_flag)));

endmodule

// File: tb/sim_i2c_mode_ctrl.sv
module sim_i2c_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, wr, wr_mss, wr_scc, wr_int, wr_clr;
  logic busy, ev_stop, match, rsv, arb, berr, byte_done;
  logic mss, act, intf, al, ber, gst, grs, gsp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .wr_i(wr), .wr_mss_i(wr_mss), .wr_scc_i(wr_scc), .wr_int_i(wr_int),
    .wr_flag_clr_i(wr_clr), .bus_busy_i(busy), .ev_stop_i(ev_stop),
    .addr_match_i(match), .rsv_ack_i(rsv), .arb_lost_i(arb),
    .bus_err_i(berr), .byte_done_i(byte_done),
    .mss_o(mss), .act_o(act), .int_o(intf), .al_o(al), .ber_o(ber),
    .gen_start_o(gst), .gen_rstart_o(grs), .gen_stop_o(gsp)
  );

  function automatic logic [7:0] outs();
    return {mss, act, intf, al, ber, gst, grs, gsp};
  endfunction

  task automatic compare(input logic [7:0] e, input string tag);
    checks++;
    if (outs() !== e) begin
      errors++;
      $display("FAIL %s: {mss,act,int,al,ber,start,rstart,stop} actual=%b expected=%b",
               tag, outs(), e);
    end
  endtask

  task automatic quiet();
    wr = 0; wr_mss = 0; wr_scc = 0; wr_int = 1; wr_clr = 0;
    ev_stop = 0; match = 0; rsv = 0; arb = 0; berr = 0; byte_done = 0;
  endtask

  // inputs are set at a falling edge; the result of the next rising edge is expected
  task automatic cyc(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    quiet();
  endtask

  task automatic wreg(input logic m, input logic s, input logic i, input logic c);
    wr = 1; wr_mss = m; wr_scc = s; wr_int = i; wr_clr = c;
  endtask

  // monitor: pops one expectation per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    en = 1; busy = 0;
    quiet();
    repeat (3) @(negedge clk);
    compare(8'b0000_0000, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(8'b0000_0000, "R1 idle after reset");

    // master write, read, repeated start, stop
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R2 pending after request");
                        cyc(8'b1100_0100, "R2 start on free bus");
                        cyc(8'b1100_0000, "R2 start is one pulse");
    byte_done = 1;      cyc(8'b1110_0000, "R13 byte sets int");
    wreg(1, 1, 1, 0);   cyc(8'b1100_0010, "R8 repeated start clears int");
    byte_done = 1;      cyc(8'b1110_0000, "R13 byte sets int again");
    wreg(1, 0, 0, 0);   cyc(8'b1100_0000, "R13 int write 0 clears");
    wreg(0, 0, 0, 0);   cyc(8'b1100_0000, "R5 mss clear with int 0 ignored");
    byte_done = 1;      cyc(8'b1110_0000, "R13 byte sets int");
    wreg(0, 1, 1, 0);   cyc(8'b1100_0001, "R9 stop wins over repeated start");
                        cyc(8'b1100_0000, "R5 mss reads 1 until stop");
    ev_stop = 1;        cyc(8'b0000_0000, "R5 stop returns to idle");

    // request deferred by busy bus
    busy = 1;
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R3 pending on busy bus");
                        cyc(8'b1000_0000, "R3 waiting while busy");
    ev_stop = 1;        cyc(8'b1000_0000, "R3 pending survives stop");
    busy = 0;           cyc(8'b1100_0100, "R3 start after busy clears");
    byte_done = 1;      cyc(8'b1110_0000, "R13 byte sets int");
    wreg(0, 0, 1, 0);   cyc(8'b1100_0001, "R5 stop request");
    ev_stop = 1;        cyc(8'b0000_0000, "R5 idle after stop");

    // address match cancels waiting request
    busy = 1;
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R4 pending");
    match = 1;          cyc(8'b0111_0000, "R4 match cancels request");
    wreg(1, 1, 1, 0);   cyc(8'b0111_0000, "R8 repeated start ignored in slave");
    ev_stop = 1;        cyc(8'b0011_0000, "R12 stop ends slave, R11 al kept");
    wreg(0, 0, 0, 1);   cyc(8'b0000_0000, "R11 flag clear write");

    // reserved address in idle
    rsv = 1;            cyc(8'b0110_0000, "R12 reserved address slave");
    wreg(0, 0, 0, 0);   cyc(8'b0100_0000, "R13 int clear in slave");
    ev_stop = 1;        cyc(8'b0000_0000, "R12 stop clears act");
    busy = 0;
    match = 1;          cyc(8'b0110_0000, "R12 own address slave");
    ev_stop = 1; wreg(0, 0, 0, 0);
                        cyc(8'b0000_0000, "R12 stop clears act");

    // arbitration loss
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R7 pending");
                        cyc(8'b1100_0100, "R7 master active");
    arb = 1;            cyc(8'b0011_0000, "R7 arbitration lost");
                        cyc(8'b0011_0000, "R11 al sticky");
    wreg(0, 0, 0, 1);   cyc(8'b0000_0000, "R11 al cleared");

    // bus error
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R6 pending");
                        cyc(8'b1100_0100, "R6 master active");
    berr = 1;           cyc(8'b0010_1000, "R6 bus error");
                        cyc(8'b0010_1000, "R11 ber sticky");
    wreg(0, 0, 0, 1);   cyc(8'b0000_0000, "R11 ber cleared");

    // disable
    busy = 1;
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R10 pending before disable");
    en = 0;             cyc(8'b0000_0000, "R10 disable clears mss");
    wreg(1, 0, 1, 0);   cyc(8'b0000_0000, "R10 write ignored while disabled");
    match = 1;          cyc(8'b0000_0000, "R10 match ignored while disabled");
    en = 1; busy = 0;   cyc(8'b0000_0000, "R10 idle on enable");

    // repeated start with int 0, pending cancel by write
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R2 pending");
                        cyc(8'b1100_0100, "R2 start");
    wreg(1, 1, 1, 0);   cyc(8'b1100_0000, "R8 repeated start ignored with int 0");
    byte_done = 1;      cyc(8'b1110_0000, "R13 byte sets int");
    wreg(1, 0, 1, 0);   cyc(8'b1110_0000, "R8 scc 0 has no effect");
    wreg(0, 0, 1, 0);   cyc(8'b1100_0001, "R5 stop request");
    ev_stop = 1;        cyc(8'b0000_0000, "R5 idle");
    busy = 1;
    wreg(1, 0, 1, 0);   cyc(8'b1000_0000, "R2 pending");
    wreg(0, 0, 1, 0);   cyc(8'b0000_0000, "R2 pending cancelled by write");
    busy = 0;           cyc(8'b0000_0000, "R2 stays idle");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule